// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the current source and destination byte addresses of one DMA channel and moves them forward as data beats are carried. Each side has its own update rule: hold, add a signed offset, step up, or step down by the beat width. A start strobe loads both addresses with their initial values. Separate reload strobes from the channel sequencer put a side back at its reload address, and can add the offset on top of it.

A side can be confined to a power-of-two window. Its low address bits then wrap inside the window and its upper bits stay put. When an update crosses the window edge, the block raises a one-cycle overflow flag for that side. That flag becomes an interrupt request only when the side's enable is set. The block does not issue bus cycles and does not count transfers. It only produces addresses and the overflow events.

Top module: `dma_addr_unit`

## Requirements
- R1: While rst_n is low, both addresses are 0 and both overflow flags and both interrupt outputs are 0.
- R2: A start pulse loads src_addr and dst_addr from src_init and dst_init at the next clock edge. On each side it takes priority over a reload and over a beat in the same cycle, and it clears that side's flag.
- R3: With update mode 2'b00 (hold), a beat leaves that side's address unchanged and raises no overflow.
- R4: With mode 2'b10 a beat adds the beat width to the address, and with mode 2'b11 it subtracts the beat width. The width is set by size: 2'b00 gives 1 byte, 2'b01 gives 2 bytes, 2'b10 gives 4 bytes. A size of 2'b11 gives a step of 0.
- R5: With mode 2'b01 a beat adds the 32-bit offset, read as a two's-complement value, modulo 2^32.
- R6: A side's reload pulse with no start sets that side's address to its reload address when the side's index select is 0, and to reload address plus offset (modulo 2^32) when it is 1. A reload takes priority over a beat in the same cycle. A reload applies no wrapping and raises no flag.
- R7: A 4-bit area value n from 1 to 15 confines a side's beat updates to the low n+1 address bits. Those bits take (low bits + step) modulo 2^(n+1), and the upper bits stay unchanged. An area of 0 gives plain 32-bit arithmetic.
- R8: A side's overflow flag is high for exactly the one cycle after a beat whose confined sum left the window, upward or downward. The flag is never raised when the area is 0.
- R9: A side's interrupt output equals its overflow flag ANDed with that side's enable input, so an enable of 0 suppresses it.
- R10: A reload on one side leaves the other side's address and flag unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load both initial addresses |
| src_init | input | 32 | Initial source address |
| dst_init | input | 32 | Initial destination address |
| beat | input | 1 | One data beat completed; advance both sides |
| src_reload | input | 1 | Restore source from its reload address |
| dst_reload | input | 1 | Restore destination from its reload address |
| size | input | 2 | Beat width: 00=1, 01=2, 10=4 bytes |
| src_mode | input | 2 | Source update: 00 hold, 01 offset, 10 up, 11 down |
| dst_mode | input | 2 | Destination update, same coding |
| offset | input | 32 | Signed offset |
| src_reload_addr | input | 32 | Source reload address |
| dst_reload_addr | input | 32 | Destination reload address |
| src_idx | input | 1 | Add offset after a source reload |
| dst_idx | input | 1 | Add offset after a destination reload |
| src_area | input | 4 | Source wrap window size code |
| dst_area | input | 4 | Destination wrap window size code |
| src_ovf_ie | input | 1 | Source overflow interrupt enable |
| dst_ovf_ie | input | 1 | Destination overflow interrupt enable |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_ovf | output | 1 | Source window overflow pulse |
| dst_ovf | output | 1 | Destination window overflow pulse |
| src_ovf_irq | output | 1 | Gated source overflow interrupt |
| dst_ovf_irq | output | 1 | Gated destination overflow interrupt |

## Verification
Addresses and overflow flags are registered. Each one shows the effect of a start, reload or beat exactly one clock edge after the cycle in which the strobe was held. The interrupt outputs follow the flag and the live enable in the same cycle. The bench drives inputs shortly after the falling edge. Its reference model takes each rising edge to find the next state, and every output is compared at the next falling edge. A registered result is therefore checked in the very cycle it is due, and the combinational interrupt is checked against the enable that is present at that moment.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int ADDR_W = 32;
  localparam int AREA_W = 4;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'b00,
    UPD_OFFSET = 2'b01,
    UPD_UP     = 2'b10,
    UPD_DOWN   = 2'b11
  } upd_mode_e;

  typedef enum logic [1:0] {
    BEAT_B1  = 2'b00,
    BEAT_B2  = 2'b01,
    BEAT_B4  = 2'b10,
    BEAT_BAD = 2'b11
  } beat_size_e;
endpackage

// File: rtl/dma_addr_delta.sv
module dma_addr_delta
  import dma_addr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] delta
);
  function automatic logic [AW-1:0] beat_bytes(input logic [1:0] sz);
    logic [AW-1:0] r;
    r = '0;
    case (beat_size_e'(sz))
      BEAT_B1: r[0] = 1'b1;
      BEAT_B2: r[1] = 1'b1;
      BEAT_B4: r[2] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [AW-1:0] step;
  assign step = beat_bytes(size);

  always_comb begin
    case (upd_mode_e'(mode))
      UPD_OFFSET: delta = offset;
      UPD_UP:     delta = step;
      UPD_DOWN:   delta = (~step) + 1'b1;
      default:    delta = '0;
    endcase
  end
endmodule

// File: rtl/dma_addr_wrap.sv
module dma_addr_wrap
  import dma_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = AREA_W
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] delta,
  input  logic [NW-1:0] area,
  output logic [AW-1:0] next_addr,
  output logic          crossed
);
  function automatic logic [AW-1:0] window_mask(input logic [NW-1:0] a);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) begin
      m[i] = (a == '0) ? 1'b1 : (i <= int'(a));
    end
    return m;
  endfunction

  logic [AW-1:0] mask;
  logic [AW-1:0] raw_sum;

  assign mask      = window_mask(area);
  assign raw_sum   = addr + delta;
  assign next_addr = (addr & ~mask) | (raw_sum & mask);
  assign crossed   = (area != '0) && ((raw_sum & ~mask) != (addr & ~mask));
endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = AREA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] init_addr,
  input  logic          beat,
  input  logic          reload,
  input  logic [AW-1:0] reload_addr,
  input  logic          idx_after_reload,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] offset,
  input  logic [NW-1:0] area,
  output logic [AW-1:0] addr,
  output logic          ovf,
  output logic          beat_take,
  output logic          reload_take,
  output logic          wrap_evt
);
  logic [AW-1:0] delta;
  logic [AW-1:0] stepped;
  logic [AW-1:0] reload_val;

  dma_addr_delta #(.AW(AW)) u_delta (
    .mode   (mode),
    .size   (size),
    .offset (offset),
    .delta  (delta)
  );

  dma_addr_wrap #(.AW(AW), .NW(NW)) u_wrap (
    .addr      (addr),
    .delta     (delta),
    .area      (area),
    .next_addr (stepped),
    .crossed   (wrap_evt)
  );

  assign reload_take = reload & ~start;
  assign beat_take   = beat & ~start & ~reload;
  assign reload_val  = reload_addr + (idx_after_reload ? offset : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= beat_take & wrap_evt;
      if (start)            addr <= init_addr;
      else if (reload_take) addr <= reload_val;
      else if (beat_take)   addr <= stepped;
    end
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = AREA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic          beat,
  input  logic          src_reload,
  input  logic          dst_reload,
  input  logic [1:0]    size,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] src_reload_addr,
  input  logic [AW-1:0] dst_reload_addr,
  input  logic          src_idx,
  input  logic          dst_idx,
  input  logic [NW-1:0] src_area,
  input  logic [NW-1:0] dst_area,
  input  logic          src_ovf_ie,
  input  logic          dst_ovf_ie,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          src_ovf,
  output logic          dst_ovf,
  output logic          src_ovf_irq,
  output logic          dst_ovf_irq
);
  localparam int SIDES = 2;

  logic [AW-1:0] s_init   [SIDES];
  logic          s_reload [SIDES];
  logic [AW-1:0] s_raddr  [SIDES];
  logic          s_idx    [SIDES];
  logic [1:0]    s_mode   [SIDES];
  logic [NW-1:0] s_area   [SIDES];
  logic [AW-1:0] s_addr   [SIDES];
  logic          s_ovf    [SIDES];
  logic          s_btake  [SIDES];
  logic          s_rtake  [SIDES];
  logic          s_wrap   [SIDES];

  assign s_init[0]   = src_init;         assign s_init[1]   = dst_init;
  assign s_reload[0] = src_reload;       assign s_reload[1] = dst_reload;
  assign s_raddr[0]  = src_reload_addr;  assign s_raddr[1]  = dst_reload_addr;
  assign s_idx[0]    = src_idx;          assign s_idx[1]    = dst_idx;
  assign s_mode[0]   = src_mode;         assign s_mode[1]   = dst_mode;
  assign s_area[0]   = src_area;         assign s_area[1]   = dst_area;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_addr_side #(.AW(AW), .NW(NW)) u_side (
      .clk              (clk),
      .rst_n            (rst_n),
      .start            (start),
      .init_addr        (s_init[g]),
      .beat             (beat),
      .reload           (s_reload[g]),
      .reload_addr      (s_raddr[g]),
      .idx_after_reload (s_idx[g]),
      .mode             (s_mode[g]),
      .size             (size),
      .offset           (offset),
      .area             (s_area[g]),
      .addr             (s_addr[g]),
      .ovf              (s_ovf[g]),
      .beat_take        (s_btake[g]),
      .reload_take      (s_rtake[g]),
      .wrap_evt         (s_wrap[g])
    );
  end

  logic src_beat_take, dst_beat_take;
  logic src_reload_take, dst_reload_take;
  logic src_wrap_evt, dst_wrap_evt;

  assign src_beat_take   = s_btake[0];
  assign dst_beat_take   = s_btake[1];
  assign src_reload_take = s_rtake[0];
  assign dst_reload_take = s_rtake[1];
  assign src_wrap_evt    = s_wrap[0];
  assign dst_wrap_evt    = s_wrap[1];

  assign src_addr    = s_addr[0];
  assign dst_addr    = s_addr[1];
  assign src_ovf     = s_ovf[0];
  assign dst_ovf     = s_ovf[1];
  assign src_ovf_irq = s_ovf[0] & src_ovf_ie;
  assign dst_ovf_irq = s_ovf[1] & dst_ovf_ie;
endmodule

// File: rtl/dma_addr_unit_chk.sv
module dma_addr_unit_chk #(
  parameter int AW = 32,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] src_init,
  input logic [AW-1:0] dst_init,
  input logic [1:0]    src_mode,
  input logic [AW-1:0] offset,
  input logic [AW-1:0] src_reload_addr,
  input logic          src_idx,
  input logic [NW-1:0] src_area,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          src_ovf,
  input logic          dst_ovf,
  input logic          src_beat_take,
  input logic          dst_beat_take,
  input logic          src_reload_take,
  input logic          dst_reload_take
);
  function automatic logic [AW-1:0] high_keep(input logic [NW-1:0] a);
    logic [AW-1:0] k;
    k = '0;
    if (a != '0) begin
      for (int i = 0; i < AW; i++) k[i] = (i > int'(a));
    end
    return k;
  endfunction

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (src_addr == $past(src_init)) && (dst_addr == $past(dst_init)));

  // R3
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_beat_take && src_mode == 2'b00) |=> $stable(src_addr) && !src_ovf);

  // R6
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_reload_take |=> src_addr == $past(src_reload_addr + (src_idx ? offset : '0)));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_beat_take && src_area != '0) |=>
      (((src_addr ^ $past(src_addr)) & high_keep($past(src_area))) == '0));

  // R8
  src_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ovf |-> $past(src_beat_take) && ($past(src_area) != '0));

  // R8
  dst_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_ovf |-> $past(dst_beat_take));

  // R10
  side_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_reload_take && !src_reload_take && !src_beat_take) |=> $stable(src_addr) && !src_ovf);
endmodule

bind dma_addr_unit dma_addr_unit_chk #(.AW(AW), .NW(NW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .src_init        (src_init),
  .dst_init        (dst_init),
  .src_mode        (src_mode),
  .offset          (offset),
  .src_reload_addr (src_reload_addr),
  .src_idx         (src_idx),
  .src_area        (src_area),
  .src_addr        (src_addr),
  .dst_addr        (dst_addr),
  .src_ovf         (src_ovf),
  .dst_ovf         (dst_ovf),
  .src_beat_take   (src_beat_take),
  .dst_beat_take   (dst_beat_take),
  .src_reload_take (src_reload_take),
  .dst_reload_take (dst_reload_take)
);

// File: tb/tb_dma_addr_unit.sv
`timescale 1ns/1ps
module tb_dma_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_init = '0, dst_init = '0;
  logic        beat = 1'b0, src_reload = 1'b0, dst_reload = 1'b0;
  logic [1:0]  size = 2'b00, src_mode = 2'b00, dst_mode = 2'b00;
  logic [31:0] offset = '0, src_reload_addr = '0, dst_reload_addr = '0;
  logic        src_idx = 1'b0, dst_idx = 1'b0;
  logic [3:0]  src_area = '0, dst_area = '0;
  logic        src_ovf_ie = 1'b0, dst_ovf_ie = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic        src_ovf, dst_ovf, src_ovf_irq, dst_ovf_irq;

  always #2.5 clk = ~clk;

  dma_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_init(src_init), .dst_init(dst_init),
    .beat(beat), .src_reload(src_reload), .dst_reload(dst_reload), .size(size),
    .src_mode(src_mode), .dst_mode(dst_mode), .offset(offset),
    .src_reload_addr(src_reload_addr), .dst_reload_addr(dst_reload_addr),
    .src_idx(src_idx), .dst_idx(dst_idx), .src_area(src_area), .dst_area(dst_area),
    .src_ovf_ie(src_ovf_ie), .dst_ovf_ie(dst_ovf_ie),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_ovf(src_ovf), .dst_ovf(dst_ovf),
    .src_ovf_irq(src_ovf_irq), .dst_ovf_irq(dst_ovf_irq)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_src = '0, m_dst = '0;
  bit          m_sovf = 1'b0, m_dovf = 1'b0;

  // Behavioural next-address model using window arithmetic on wide integers
  task automatic advance(input logic [31:0] a, input logic [1:0] md, input logic [3:0] ar,
                         output logic [31:0] na, output bit crossed);
    longint step, d, win, lo, sum, nlo;
    step = (size == 2'b11) ? 0 : (64'd1 << size);
    case (md)
      2'b00: d = 0;
      2'b01: d = longint'($signed(offset));
      2'b10: d = step;
      default: d = -step;
    endcase
    win = (ar == 0) ? 64'h1_0000_0000 : (64'd1 << (ar + 1));
    lo  = longint'({32'd0, a}) % win;
    sum = lo + d;
    crossed = (ar != 0) && (sum < 0 || sum >= win);
    nlo = ((sum % win) + win) % win;
    na  = 32'(longint'({32'd0, a}) - lo + nlo);
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] na;
    bit c;
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_sovf = 0; m_dovf = 0;
    end else begin
      m_sovf = 0; m_dovf = 0;
      if (start) m_src = src_init;
      else if (src_reload) m_src = src_reload_addr + (src_idx ? offset : 32'd0);
      else if (beat) begin advance(m_src, src_mode, src_area, na, c); m_src = na; m_sovf = c; end
      if (start) m_dst = dst_init;
      else if (dst_reload) m_dst = dst_reload_addr + (dst_idx ? offset : 32'd0);
      else if (beat) begin advance(m_dst, dst_mode, dst_area, na, c); m_dst = na; m_dovf = c; end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("src_addr", src_addr, m_src);
      cmp("dst_addr", dst_addr, m_dst);
      cmp("src_ovf", {31'd0, src_ovf}, {31'd0, m_sovf});
      cmp("dst_ovf", {31'd0, dst_ovf}, {31'd0, m_dovf});
      cmp("src_ovf_irq", {31'd0, src_ovf_irq}, {31'd0, m_sovf & src_ovf_ie});
      cmp("dst_ovf_irq", {31'd0, dst_ovf_irq}, {31'd0, m_dovf & dst_ovf_ie});
    end
  end

  task automatic tick(input bit b, input bit sr, input bit dr, input bit st);
    @(negedge clk); #1;
    beat = b; src_reload = sr; dst_reload = dr; start = st;
  endtask

  task automatic go_start(input logic [31:0] s, input logic [31:0] d);
    src_init = s; dst_init = d;
    tick(0, 0, 0, 1);
  endtask

  initial begin
    // R1: reset state held for several cycles
    cur_req = "R1";
    repeat (4) tick(0, 0, 0, 0);
    rst_n = 1'b1;
    // R2: start loads both sides
    cur_req = "R2";
    go_start(32'h1000_0000, 32'h2000_00F0);
    tick(0, 0, 0, 0);
    // R4: up/down by each size, size 11 holds
    cur_req = "R4";
    src_mode = 2'b10; dst_mode = 2'b11;
    for (int sz = 0; sz < 4; sz++) begin
      size = 2'(sz);
      repeat (3) tick(1, 0, 0, 0);
    end
    tick(0, 0, 0, 0);
    // R3: hold mode
    cur_req = "R3";
    size = 2'b10; src_mode = 2'b00; dst_mode = 2'b00;
    repeat (3) tick(1, 0, 0, 0);
    // R5: positive and negative offsets, wrap modulo 2^32
    cur_req = "R5";
    src_mode = 2'b01; dst_mode = 2'b01; offset = 32'h0000_0100;
    repeat (2) tick(1, 0, 0, 0);
    offset = 32'hFFFF_FFF0;
    repeat (2) tick(1, 0, 0, 0);
    go_start(32'h0000_0004, 32'hFFFF_FFF8);
    offset = 32'h0000_0010;
    tick(1, 0, 0, 0);
    offset = 32'hFFFF_FFF8;
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 0);
    // R7 R8 R9: windows, overflow in both directions, enable gating
    cur_req = "R7";
    go_start(32'h0000_3FF4, 32'h5000_0002);
    src_mode = 2'b10; dst_mode = 2'b11; src_area = 4'd3; dst_area = 4'd2;
    src_ovf_ie = 1'b1; dst_ovf_ie = 1'b0; size = 2'b10;
    tick(1, 0, 0, 0);
    cur_req = "R8";
    size = 2'b01;
    repeat (4) tick(1, 0, 0, 0);
    size = 2'b10;
    repeat (4) tick(1, 0, 0, 0);
    cur_req = "R9";
    src_ovf_ie = 1'b0; dst_ovf_ie = 1'b1;
    repeat (6) tick(1, 0, 0, 0);
    src_area = 4'd15; src_mode = 2'b01; offset = 32'h0001_0000;
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 0);
    // R6: reload with and without index, reload beating a beat
    cur_req = "R6";
    src_area = 4'd0; dst_area = 4'd0; src_mode = 2'b10; dst_mode = 2'b10;
    src_reload_addr = 32'hA000_0000; dst_reload_addr = 32'hB000_0000;
    offset = 32'h0000_0040; src_idx = 1'b0; dst_idx = 1'b1;
    tick(0, 1, 1, 0);
    tick(1, 0, 0, 0);
    tick(1, 1, 0, 0);
    tick(1, 0, 1, 0);
    // R10: one side reloads, the other is left alone
    cur_req = "R10";
    tick(0, 0, 1, 0);
    tick(0, 1, 0, 0);
    tick(0, 0, 0, 0);
    // R2: start wins over reload and beat
    cur_req = "R2";
    src_init = 32'h1234_5678; dst_init = 32'h8765_4320;
    tick(1, 1, 1, 1);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    @(negedge clk); #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog %s actual running expected finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule